// File: doc/BRIEF.md
# Single-Bit Asynchronous Static RAM Sequencer

This block lets synchronous logic read and write one bit at a time in an external asynchronous static RAM of 65,536 one-bit words. The RAM has separate data-in and data-out pins and two active-low strobes, a chip select and a write enable. On the user side a request carries an address, a direction flag and a write bit. A read returns its bit together with a one-cycle valid pulse.

Each timing limit of the RAM is a parameter in picoseconds, as is the clock period. At elaboration every limit becomes a whole number of clock cycles, rounded up. Each transfer then runs through the same phases: setup, strobe, hold and recovery. In a write, the write enable pulse sits fully inside the chip-select window. The address and data bit stay fixed for the whole time chip select is low. Read data comes back through a synchronizer before it is captured. Between transfers both strobes are high, which keeps the RAM in standby.

Top module: `sram_bitctl`

## Requirements
- R1: Once reset has been released and the internal reset synchronizer has let go, `mem_cs_n` and `mem_we_n` are both 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the transfer has ended. A request held high during a transfer waits and is taken on the first edge after `req_ready` returns to 1.
- R3: At the edge that accepts a request, the address (and, for a write, `mem_din`) is loaded and `mem_cs_n` falls, all at once. `mem_we_n` stays high for max(1, setup cycles) cycles before it falls.
- R4: During a write, `mem_we_n` is low for max(pulse-width cycles, data-setup cycles) consecutive cycles while `mem_cs_n` stays low.
- R5: During a write, `mem_we_n` returns high max(1, data-hold cycles) cycles before `mem_cs_n` rises. `mem_din` keeps its value across the rise of `mem_we_n`.
- R6: After a write, `mem_cs_n` stays high for max(1, recovery cycles, write-cycle cycles minus the cycles chip select was low) cycles before the block is ready again.
- R7: During a read, `mem_we_n` stays high throughout. `mem_cs_n` is low for S + A + 2 cycles, where S is the setup length and A = max(1, access cycles − S). Access cycles is the larger of the address and chip-select access times, converted to cycles.
- R8: A read samples `mem_dout` at the edge that ends the access window and passes the sample through two flops. The bit appears on `rsp_rdata` while `rsp_valid` is 1 for exactly one cycle, the first cycle after `mem_cs_n` rises. Read recovery lasts max(1, read-cycle cycles − (S + A + 2)) cycles.
- R9: `mem_addr` changes only at an edge where `mem_cs_n` was high just before that edge.
- R10: A time t becomes ceil(t / clock period) cycles, and a time of 0 becomes 0 cycles. With the default 20 ns clock, `req_ready` is low for 4 cycles after a write is accepted and for 5 cycles after a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 1 | Bit to write |
| req_ready | output | 1 | Block idle and able to take a request |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 1 | Bit read from the RAM |
| mem_addr | output | 16 | RAM address lines |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_din | output | 1 | RAM data input pin |
| mem_dout | input | 1 | RAM data output pin |

## Verification
The bench's RAM model drives the inverse of the stored bit until the access window has fully passed. A design that samples even one cycle too early therefore returns wrong read data. The model commits a write only when the strobe overlap ends, and it flags any change of address while chip select is low and any change of data across the rise of write enable. This catches a design that releases both strobes together or moves the address too soon. Requests are held high across busy transfers, so a design that accepts while busy or drops a waiting request goes out of step with the cycle-by-cycle reference. The bench also counts busy cycles at the ports and writes and reads back the two end addresses, which exposes wrong rounding or a truncated address.

// File: rtl/sram_bitctl_pkg.sv
`timescale 1ns/1ps
package sram_bitctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_STROBE  = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RECOVER = 3'd4
  } xfer_state_e;

  // Convert a time in ps to clock cycles, rounded up; zero stays zero.
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    if (t_ps <= 0) return 0;
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bitctl_timer.sv
`timescale 1ns/1ps
module sram_bitctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!done) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_bitctl_rdcap.sv
`timescale 1ns/1ps
module sram_bitctl_rdcap #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_async,
  input  logic cap_stb,
  output logic rsp_valid,
  output logic rsp_rdata
);

  logic [SYNC_STAGES-1:0] sy_q;
  logic                   vld_q;
  logic                   dat_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q[0] <= 1'b0;
        else        sy_q[0] <= din_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q[g] <= 1'b0;
        else        sy_q[g] <= sy_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      vld_q <= cap_stb;
      if (cap_stb) dat_q <= sy_q[SYNC_STAGES-1];
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = dat_q;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8

endmodule

// File: rtl/sram_bitctl_seq.sv
`timescale 1ns/1ps
module sram_bitctl_seq
  import sram_bitctl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 3,
  parameter int SET_LEN = 1,
  parameter int STB_W   = 1,
  parameter int HLD_W   = 1,
  parameter int REC_W   = 1,
  parameter int STB_R   = 1,
  parameter int HLD_R   = 2,
  parameter int REC_R   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_din,
  output logic              cap_stb
);

  xfer_state_e      st_q, st_d;
  logic             wr_q, wr_d;
  logic             rdy_q, rdy_d;
  logic             cs_n_q, cs_n_d;
  logic             we_n_q, we_n_d;
  logic [ADDR_W-1:0] addr_q;
  logic             din_q;
  logic             take;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             tm_done;

  sram_bitctl_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .done     (tm_done)
  );

  assign take = req_valid && rdy_q;

  // next-state process
  always_comb begin
    st_d   = st_q;
    wr_d   = wr_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (take) begin
          st_d   = ST_SETUP;
          wr_d   = req_write;
          ld     = 1'b1;
          ld_val = CNT_W'(SET_LEN - 1);
        end
      end
      ST_SETUP: begin
        if (tm_done) begin
          st_d   = ST_STROBE;
          ld     = 1'b1;
          ld_val = wr_q ? CNT_W'(STB_W - 1) : CNT_W'(STB_R - 1);
        end
      end
      ST_STROBE: begin
        if (tm_done) begin
          st_d   = ST_HOLD;
          ld     = 1'b1;
          ld_val = wr_q ? CNT_W'(HLD_W - 1) : CNT_W'(HLD_R - 1);
        end
      end
      ST_HOLD: begin
        if (tm_done) begin
          st_d   = ST_RECOVER;
          ld     = 1'b1;
          ld_val = wr_q ? CNT_W'(REC_W - 1) : CNT_W'(REC_R - 1);
        end
      end
      ST_RECOVER: begin
        if (tm_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    cs_n_d = (st_d == ST_IDLE) || (st_d == ST_RECOVER);
    we_n_d = !((st_d == ST_STROBE) && wr_d);
    rdy_d  = (st_d == ST_IDLE);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= 1'b0;
      rdy_q  <= 1'b0;
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      addr_q <= '0;
      din_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wr_q   <= wr_d;
      rdy_q  <= rdy_d;
      cs_n_q <= cs_n_d;
      we_n_q <= we_n_d;
      if (take)              addr_q <= req_addr;
      if (take && req_write) din_q  <= req_wdata;
    end
  end

  assign req_ready = rdy_q;
  assign mem_addr  = addr_q;
  assign mem_cs_n  = cs_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_din   = din_q;
  assign cap_stb   = (st_q == ST_HOLD) && !wr_q && tm_done;

  AST_WE_FALLS_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n)); // R3
  AST_WE_RISES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> $past(mem_we_n)); // R5
  AST_DIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $stable(mem_din)); // R5
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready); // R2

endmodule

// File: rtl/sram_bitctl.sv
`timescale 1ns/1ps
module sram_bitctl
  import sram_bitctl_pkg::*;
#(
  parameter int CLK_PS      = 20000,
  parameter int ADDR_W      = 16,
  parameter int T_AS_PS     = 0,
  parameter int T_WP_PS     = 20000,
  parameter int T_DW_PS     = 15000,
  parameter int T_DH_PS     = 5000,
  parameter int T_WR_PS     = 0,
  parameter int T_WC_PS     = 25000,
  parameter int T_AA_PS     = 25000,
  parameter int T_ACS_PS    = 25000,
  parameter int T_RC_PS     = 25000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_din,
  input  logic              mem_dout
);

  localparam int AS_C    = cyc_of(T_AS_PS, CLK_PS);
  localparam int WP_C    = cyc_of(T_WP_PS, CLK_PS);
  localparam int DW_C    = cyc_of(T_DW_PS, CLK_PS);
  localparam int DH_C    = cyc_of(T_DH_PS, CLK_PS);
  localparam int WR_C    = cyc_of(T_WR_PS, CLK_PS);
  localparam int WC_C    = cyc_of(T_WC_PS, CLK_PS);
  localparam int ACC_C   = imax(cyc_of(T_AA_PS, CLK_PS), cyc_of(T_ACS_PS, CLK_PS));
  localparam int RC_C    = cyc_of(T_RC_PS, CLK_PS);

  localparam int SET_LEN = imax(1, AS_C);
  localparam int STB_W   = imax(1, imax(WP_C, DW_C));
  localparam int HLD_W   = imax(1, DH_C);
  localparam int REC_W   = imax(1, imax(WR_C, WC_C - (SET_LEN + STB_W + HLD_W)));
  localparam int STB_R   = imax(1, ACC_C - SET_LEN);
  localparam int HLD_R   = SYNC_STAGES;
  localparam int REC_R   = imax(1, RC_C - (SET_LEN + STB_R + HLD_R));
  localparam int MAX_LEN = imax(imax(imax(SET_LEN, STB_W), imax(HLD_W, REC_W)),
                                imax(imax(STB_R, HLD_R), REC_R));
  localparam int CNT_W   = imax(1, $clog2(MAX_LEN + 1));

  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic cap_stb;

  sram_bitctl_seq #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .SET_LEN (SET_LEN),
    .STB_W   (STB_W),
    .HLD_W   (HLD_W),
    .REC_W   (REC_W),
    .STB_R   (STB_R),
    .HLD_R   (HLD_R),
    .REC_R   (REC_R)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_din   (mem_din),
    .cap_stb   (cap_stb)
  );

  sram_bitctl_rdcap #(.SYNC_STAGES(SYNC_STAGES)) u_rdcap (
    .clk       (clk),
    .rst_n     (rst_sn),
    .din_async (mem_dout),
    .cap_stb   (cap_stb),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  AST_VALID_WHILE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_valid |-> (mem_cs_n && mem_we_n)); // R8

endmodule

// File: tb/sim_sram_bitctl.sv
`timescale 1ns/1ps
module sim_sram_bitctl;

  localparam int CLK_PS = 20000;

  function automatic int ceil_c(input int t);
    if (t <= 0) return 0;
    return (t + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths, from the requirements
  localparam int S   = mx(1, ceil_c(0));
  localparam int P   = mx(1, mx(ceil_c(20000), ceil_c(15000)));
  localparam int H   = mx(1, ceil_c(5000));
  localparam int RW  = mx(1, mx(ceil_c(0), ceil_c(25000) - (S + P + H)));
  localparam int ACC = mx(ceil_c(25000), ceil_c(25000));
  localparam int A   = mx(1, ACC - S);
  localparam int RR  = mx(1, ceil_c(25000) - (S + A + 2));

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_wdata;
  logic [15:0] req_addr;
  logic        req_ready, rsp_valid, rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_din;
  logic        mem_dout;

  always #10 clk = ~clk;

  sram_bitctl #(
    .CLK_PS(CLK_PS), .ADDR_W(16), .T_AS_PS(0), .T_WP_PS(20000), .T_DW_PS(15000),
    .T_DH_PS(5000), .T_WR_PS(0), .T_WC_PS(25000), .T_AA_PS(25000),
    .T_ACS_PS(25000), .T_RC_PS(25000), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_din(mem_din), .mem_dout(mem_dout)
  );

  int n_vec  = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM on the pins ----------------
  bit        ram [int];
  logic      p_cs = 1, p_we = 1, p_din = 0;
  logic [15:0] p_addr = '0;
  int        lowcnt = 0;

  function automatic bit ram_rd(input int a);
    return ram.exists(a) ? ram[a] : 1'b0;
  endfunction

  initial mem_dout = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (!p_cs && !p_we && (mem_cs_n || mem_we_n)) begin
        ram[int'(p_addr)] = p_din;
        chk("R5", "din across strobe end", {15'd0, mem_din}, {15'd0, p_din});
      end
      if (!p_cs && !p_we && !mem_cs_n && !mem_we_n)
        chk("R5", "din during strobe", {15'd0, mem_din}, {15'd0, p_din});
      if (mem_addr !== p_addr)
        chk("R9", "cs_n before address change", {15'd0, p_cs}, 16'd1);
    end
    if (!mem_cs_n && mem_we_n) lowcnt++; else lowcnt = 0;
    if (!mem_cs_n && mem_we_n)
      mem_dout = (lowcnt >= ACC) ? ram_rd(int'(mem_addr)) : ~ram_rd(int'(mem_addr));
    else
      mem_dout = 1'b0;
    p_cs = mem_cs_n; p_we = mem_we_n; p_din = mem_din; p_addr = mem_addr;
  end

  // ---------------- cycle reference model ----------------
  typedef struct {
    bit cs; bit we; bit rdy; bit rv; bit rd; logic [15:0] addr; string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  bit   shadow [int];
  bit   model_on = 0;

  function automatic exp_t mk(bit cs, bit we, bit rv, bit rd, logic [15:0] a, string tag);
    exp_t e;
    e.cs = cs; e.we = we; e.rdy = 1'b0; e.rv = rv; e.rd = rd; e.addr = a; e.tag = tag;
    return e;
  endfunction

  function automatic void push_xfer(bit w, logic [15:0] a, bit d);
    if (w) begin
      shadow[int'(a)] = d;
      for (int i = 0; i < S; i++)  q.push_back(mk(0, 1, 0, 0, a, "R3"));
      for (int i = 0; i < P; i++)  q.push_back(mk(0, 0, 0, 0, a, "R4"));
      for (int i = 0; i < H; i++)  q.push_back(mk(0, 1, 0, 0, a, "R5"));
      for (int i = 0; i < RW; i++) q.push_back(mk(1, 1, 0, 0, a, "R6"));
    end else begin
      bit v = shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0;
      for (int i = 0; i < S + A + 2; i++) q.push_back(mk(0, 1, 0, 0, a, "R7"));
      q.push_back(mk(1, 1, 1, v, a, "R8"));
      for (int i = 1; i < RR; i++) q.push_back(mk(1, 1, 0, 0, a, "R7"));
    end
  endfunction

  initial begin
    cur = mk(1, 1, 0, 0, '0, "R2");
    cur.rdy = 1'b1;
  end

  always @(posedge clk) begin
    if (model_on) begin
      if (q.size() == 0 && cur.rdy && req_valid) push_xfer(req_write, req_addr, req_wdata);
      if (q.size() > 0) cur = q.pop_front();
      else begin
        cur = mk(1, 1, 0, 0, cur.addr, "R2");
        cur.rdy = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !done_flag) begin
      chk(cur.tag, "cs_n",  {15'd0, mem_cs_n},  {15'd0, cur.cs});
      chk(cur.tag, "we_n",  {15'd0, mem_we_n},  {15'd0, cur.we});
      chk("R2",    "ready", {15'd0, req_ready}, {15'd0, cur.rdy});
      chk(cur.tag, "rsp_valid", {15'd0, rsp_valid}, {15'd0, cur.rv});
      if (cur.rv) chk("R8", "rsp_rdata", {15'd0, rsp_rdata}, {15'd0, cur.rd});
      if (!cur.cs) chk("R9", "mem_addr", mem_addr, cur.addr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input bit w, input logic [15:0] a, input bit d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      bit r;
      r = req_ready;
      @(negedge clk);
      if (r) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic busy_len(input bit w, input logic [15:0] a, input bit d, input int exp);
    int n;
    while (!req_ready) @(negedge clk);
    xfer(w, a, d);
    n = 0;
    while (!req_ready) begin
      n++;
      @(negedge clk);
    end
    chk("R10", w ? "write busy cycles" : "read busy cycles", 16'(n), 16'(exp));
  endtask

  task automatic report;
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual still running expected finished");
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wdata = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset / standby state
    chk("R1", "cs_n idle",   {15'd0, mem_cs_n},  16'd1);
    chk("R1", "we_n idle",   {15'd0, mem_we_n},  16'd1);
    chk("R1", "rsp idle",    {15'd0, rsp_valid}, 16'd0);
    chk("R1", "ready idle",  {15'd0, req_ready}, 16'd1);
    model_on = 1;
    @(negedge clk);

    // never-written address reads 0; end addresses
    xfer(0, 16'h1234, 0);
    xfer(1, 16'h0000, 1);
    xfer(1, 16'hFFFF, 1);
    xfer(0, 16'h0000, 0);
    xfer(0, 16'hFFFF, 0);
    xfer(0, 16'h0001, 0);
    xfer(0, 16'h7FFF, 0);

    // R10: busy lengths at the default clock
    busy_len(1, 16'h00A5, 1, S + P + H + RW);
    busy_len(0, 16'h00A5, 0, S + A + 2 + RR);
    busy_len(1, 16'h00A5, 0, 4);
    busy_len(0, 16'h00A5, 0, 5);

    // overwrite with the opposite value
    xfer(1, 16'hFFFF, 0);
    xfer(0, 16'hFFFF, 0);

    // back-to-back held requests, alternating bit pattern
    for (int i = 0; i < 16; i++) xfer(1, 16'(i * 4099), bit'(i[0] ^ i[2]));
    for (int i = 0; i < 16; i++) xfer(0, 16'(i * 4099), 0);
    for (int i = 0; i < 8; i++) begin
      xfer(1, 16'(16'hF000 + i), bit'(~i[1]));
      xfer(0, 16'(16'hF000 + i), 0);
    end

    repeat (10) @(negedge clk);
    chk("R1", "final cs_n", {15'd0, mem_cs_n}, 16'd1);
    chk("R1", "final we_n", {15'd0, mem_we_n}, 16'd1);
    report();
  end

endmodule